// File: doc/BRIEF.md
# Accelerator Interrupt Register Block

This block is a small set of memory-mapped registers in the host interface of a graphics accelerator. It lets the host read a fixed version word, see whether a pipeline-state event has raised an interrupt, clear that interrupt, and turn the interrupt line on or off with one global enable bit. Per-source masking of pipeline-state events happens upstream. This block therefore sees a single event pulse that has already been qualified.

The host reaches the registers over a simple synchronous bus. An access carries an address, a write strobe with write data, and a read strobe. Read data is registered and appears one clock after the read strobe.

Clearing the pending flag does not depend on the data written. Any write to the pending register clears it. An event in the same cycle as that write takes priority, so no event is lost. The interrupt output is the registered AND of the pending flag and the enable bit.

Top module: `gfx_irq_regs`

## Requirements
- R1: After synchronous reset, the pending flag, the enable bit, `irq_out` and `bus_rdata` are all 0.
- R2: A read of offset 0x10 returns 0x01020100 on `bus_rdata` one clock after `bus_rd`. The major version 0x01 is in bits [31:24] and the minor version 0x020100 is in bits [23:0].
- R3: A read of offset 0x40 returns the pending flag in bit 0, with bits [31:1] reading 0.
- R4: A cycle with `pipe_evt` high sets the pending flag at that clock edge, whatever the state of the enable bit.
- R5: A write to offset 0x40 clears the pending flag, whatever the value of `bus_wdata`.
- R6: When `pipe_evt` is high in the same cycle as a write to offset 0x40, the pending flag is 1 after that edge.
- R7: A write to offset 0x44 loads `bus_wdata[0]` into the enable bit. A read of offset 0x44 returns the enable bit in bit 0, with bits [31:1] reading 0.
- R8: `irq_out` equals the AND of the pending flag and the enable bit as they stood before the previous clock edge. Setting the enable bit while an event is pending raises `irq_out` one cycle later.
- R9: A read of any offset other than 0x10, 0x40 and 0x44 returns 0. Writes to 0x10 or to an unmapped offset change neither the pending flag nor the enable bit.
- R10: After a clear, a later event sets the pending flag again and raises a fresh interrupt when enabled.
- R11: In any cycle without `bus_rd`, `bus_rdata` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pipe_evt | input | 1 | Qualified pipeline-state event pulse |
| irq_out | output | 1 | Interrupt request toward the host |

## Verification
The checker's assertions hold every cycle. They cover event capture, the clear that only applies when no event arrives in the same cycle, the event-over-clear priority, stability of the pending flag when neither acts, the registered AND that forms `irq_out`, the version readback and the zero readback of unmapped offsets. Only the bench's scenarios can show the longer histories. These are an event that waits under a closed mask and fires once the mask opens, a repeated clear-and-re-raise, writes with all-zero and all-one data, and writes to read-only or unmapped offsets followed by readback.

// File: rtl/gfx_irq_regs_pkg.sv
package gfx_irq_regs_pkg;

    localparam int DATA_W = 32;

    localparam logic [31:0] OFS_VERSION = 32'h0000_0010;
    localparam logic [31:0] OFS_PENDING = 32'h0000_0040;
    localparam logic [31:0] OFS_ENABLE  = 32'h0000_0044;

    localparam logic [7:0]  VER_MAJOR = 8'h01;
    localparam logic [23:0] VER_MINOR = 24'h020100;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_VERSION = 2'd1,
        SEL_PENDING = 2'd2,
        SEL_ENABLE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pending;
        logic enable;
    } irq_state_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        case (ofs)
            OFS_VERSION: return SEL_VERSION;
            OFS_PENDING: return SEL_PENDING;
            OFS_ENABLE:  return SEL_ENABLE;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] version_word();
        return {VER_MAJOR, VER_MINOR};
    endfunction

endpackage

// File: rtl/gfx_irq_addr_dec.sv
module gfx_irq_addr_dec
    import gfx_irq_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] addr_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_ext = {{PAD_W{1'b0}}, addr};
        end else begin : g_nopad
            assign addr_ext = addr[31:0];
        end
    endgenerate

    assign sel = decode_ofs(addr_ext);
endmodule

// File: rtl/gfx_irq_core.sv
module gfx_irq_core
    import gfx_irq_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  reg_sel_e   sel,
    input  logic       wr,
    input  logic       wbit,
    input  logic       evt,
    output irq_state_t state,
    output logic       irq
);
    irq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr && sel == SEL_PENDING) st_d.pending = 1'b0;
        if (evt)                      st_d.pending = 1'b1;
        if (wr && sel == SEL_ENABLE)  st_d.enable  = wbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            irq  <= 1'b0;
        end else begin
            st_q <= st_d;
            irq  <= st_q.pending & st_q.enable;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/gfx_irq_rd_mux.sv
module gfx_irq_rd_mux
    import gfx_irq_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  irq_state_t        state,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_VERSION: rd_val = version_word();
            SEL_PENDING: rd_val[0] = state.pending;
            SEL_ENABLE:  rd_val[0] = state.enable;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd ? rd_val : '0;
    end
endmodule

// File: rtl/gfx_irq_regs.sv
module gfx_irq_regs
    import gfx_irq_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              pipe_evt,
    output logic              irq_out
);
    reg_sel_e   sel;
    irq_state_t state;
    logic       pend_q;
    logic       en_q;

    gfx_irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gfx_irq_core u_core (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wr    (bus_wr),
        .wbit  (bus_wdata[0]),
        .evt   (pipe_evt),
        .state (state),
        .irq   (irq_out)
    );

    gfx_irq_rd_mux u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .sel   (sel),
        .state (state),
        .rdata (bus_rdata)
    );

    assign pend_q = state.pending;
    assign en_q   = state.enable;
endmodule

// File: rtl/gfx_irq_regs_chk.sv
module gfx_irq_regs_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic              evt,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              pending,
    input logic              enable
);
    localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(32'h10);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(32'h40);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(32'h44);

    logic mapped;
    assign mapped = (addr == A_VER) || (addr == A_PEND) || (addr == A_EN);

    a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
        evt |=> pending);

    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_PEND && !evt) |=> !pending);

    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_PEND && evt) |=> pending);

    a_r9_pending_holds: assert property (@(posedge clk) disable iff (rst)
        (!evt && !(wr && addr == A_PEND)) |=> $stable(pending));

    a_r9_enable_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == A_EN) |=> $stable(enable));

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (pending && enable) |=> irq);

    a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
        !(pending && enable) |=> !irq);

    a_r2_version: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_VER) |=> rdata == 32'h0102_0100);

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && !mapped) |=> rdata == 32'h0);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == 32'h0);
endmodule

bind gfx_irq_regs gfx_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .evt     (pipe_evt),
    .rdata   (bus_rdata),
    .irq     (irq_out),
    .pending (pend_q),
    .enable  (en_q)
);

// File: tb/gfx_irq_regs_bench.sv
`timescale 1ns/1ps
module gfx_irq_regs_bench;
    localparam int ADDR_W = 12;
    localparam int WD_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              pipe_evt = 1'b0;
    logic              irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic m_pend = 1'b0;
    logic m_en = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gfx_irq_regs #(.ADDR_W(ADDR_W)) u_gfx_irq_regs (
        .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
        .bus_rdata, .pipe_evt, .irq_out
    );

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a,
                                             input logic p, input logic e);
        case (a)
            12'h010: return 32'h0102_0100;
            12'h040: return {31'b0, p};
            12'h044: return {31'b0, e};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic [ADDR_W-1:0] a, input logic w,
                        input logic [31:0] wd, input logic r, input logic ev);
        logic [31:0] e_rd;
        logic        e_irq;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = wd; bus_rd = r; pipe_evt = ev;
        e_rd  = r ? exp_read(a, m_pend, m_en) : 32'h0;
        e_irq = m_pend & m_en;
        if (w && a == 12'h040) m_pend = 1'b0;
        if (ev) m_pend = 1'b1;
        if (w && a == 12'h044) m_en = wd[0];
        @(posedge clk); #2;
        check({tag, " rdata"}, bus_rdata, e_rd);
        check({tag, " irq"}, {31'b0, irq_out}, {31'b0, e_irq});
        bus_wr = 1'b0; bus_rd = 1'b0; pipe_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 rdata reset", bus_rdata, 32'h0);
        check("R1 irq reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk); rst = 1'b0;

        step("R1 pending after reset", 12'h040, 0, 0, 1, 0);
        step("R1 enable after reset", 12'h044, 0, 0, 1, 0);
        step("R2 version", 12'h010, 0, 0, 1, 0);
        step("R9 write version", 12'h010, 1, 32'hFFFF_FFFF, 0, 0);
        step("R2 version after write", 12'h010, 0, 0, 1, 0);
        step("R4 event masked", 12'h000, 0, 0, 0, 1);
        step("R3 pending read", 12'h040, 0, 0, 1, 0);
        step("R8 still masked", 12'h000, 0, 0, 0, 0);
        step("R7 enable write all ones", 12'h044, 1, 32'hFFFF_FFFF, 0, 0);
        step("R8 late enable", 12'h044, 0, 0, 1, 0);
        step("R8 irq held", 12'h000, 0, 0, 0, 0);
        step("R9 unmapped write", 12'h048, 1, 32'h0, 0, 0);
        step("R9 unmapped read", 12'h048, 0, 0, 1, 0);
        step("R9 state kept", 12'h040, 0, 0, 1, 0);
        step("R5 clear zero data", 12'h040, 1, 32'h0, 0, 0);
        step("R5 pending cleared", 12'h040, 0, 0, 1, 0);
        step("R8 irq drops", 12'h000, 0, 0, 0, 0);
        step("R10 re-raise", 12'h000, 0, 0, 0, 1);
        step("R10 irq again", 12'h040, 0, 0, 1, 0);
        step("R6 event with clear", 12'h040, 1, 32'h1, 0, 1);
        step("R6 pending kept", 12'h040, 0, 0, 1, 0);
        step("R5 clear ones data", 12'h040, 1, 32'hFFFF_FFFF, 1, 0);
        step("R7 disable", 12'h044, 1, 32'hFFFF_FFFE, 0, 1);
        step("R7 enable read", 12'h044, 0, 0, 1, 0);
        step("R11 idle", 12'h010, 0, 0, 0, 0);

        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            int k;
            k = $urandom_range(0, 4);
            case (k)
                0: a = 12'h010;
                1: a = 12'h040;
                2: a = 12'h044;
                default: a = ADDR_W'($urandom);
            endcase
            step("R8 R9 random", a, $urandom_range(0, 2) == 0, $urandom,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= WD_CYCLES);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule